// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a single-slot mailbox between a host processor and a power-management microcontroller. The host uses a plain 32-bit register bus. It loads up to 16 bytes of payload and two pointer words, then writes a command word. That write posts the opcode, the sub-command, the payload length and an interrupt request together, and it sets busy. The host then polls busy or waits for the interrupt. After completion it reads the status word and the four reply words.

The controller side has two valid/ready channels. On the command channel the block holds `ctl_cmd_valid` high, with every field frozen, until the controller raises `ctl_cmd_ready`. That makes back-pressure from the controller lossless. On the completion channel the block raises `cpl_ready` only after the command has been taken and while busy is still 1. A completion offered at any other time waits; the block never drops it. A completion is accepted in a cycle where `cpl_valid` and `cpl_ready` are both high. That acceptance loads the error flag, the error code and the reply words, and it clears busy.

Register offsets are on `bus_addr`, and only word-aligned offsets decode:

| Offset | Register |
|---|---|
| 0x00 | command |
| 0x04 | status |
| 0x08 | source pointer |
| 0x0C | destination pointer |
| 0x80–0x8C | write buffer |
| 0x90–0x9C | read buffer |

Top module: `cmd_mailbox`

## Requirements
- R1: After reset, busy, error, the interrupt flag, the command id and the error code read 0. The status word reads only the initiator id (parameter `INIT_ID`) in bits [15:8]. `irq`, `ctl_cmd_valid` and `cpl_ready` are 0.
- R2: An accepted command write at 0x00 decodes the opcode from bits [7:0], the interrupt request from bit 8, the sub-command from bits [15:12] and the byte length from bits [23:16]. These fields appear on the controller outputs together with both pointer registers (source at 0x08, destination at 0x0C).
- R3: Status bit 0 (busy) reads 1 from the cycle after an accepted command write until a completion is accepted, and it reads 0 in the cycle after that acceptance.
- R4: The four payload words written at 0x80, 0x84, 0x88 and 0x8C form `ctl_payload`, with byte k at bits [8k+7:8k]. Bytes at or beyond the posted length are driven as 0. Reads of the write buffer return 0.
- R5: A command write whose length field exceeds 16 does not start a command. Busy stays 0, and the status reads error bit 1 = 1 and code 4 (invalid) in bits [23:16].
- R6: An accepted completion loads status bit 1 from `cpl_err` and bits [23:16] from `cpl_code`. Both keep their values until the next accepted command write, which clears them to 0. Codes: 0 none, 1 not supported, 2 not serviced, 3 unable to service, 4 invalid, 5 failed, 6 security, 7 unsigned image.
- R7: After completion, reply word k of `cpl_data` (bits [32k+31:32k]) reads at offset 0x90+4k. Bus writes to the read buffer have no effect.
- R8: When the command had bit 8 set, completion sets status bit 2 and `irq`. Writing the status register with bit 2 set clears both. A command without bit 8 never raises them.
- R9: While busy, writes to the command register, the pointers and the write buffer are ignored. The in-flight command, payload and pointers are unchanged.
- R10: Status bits [7:4] hold the sub-command of the most recently accepted command.
- R11: `ctl_cmd_valid` stays 1 with stable fields until `ctl_cmd_ready`. `cpl_ready` is 1 only while busy after the command has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| bus_wr | input | 1 | host write strobe |
| bus_rd | input | 1 | host read strobe |
| bus_addr | input | 8 | byte offset |
| bus_wdata | input | 32 | host write data |
| bus_rdata | output | 32 | host read data, same cycle, 0 when not reading |
| ctl_cmd_valid | output | 1 | command offered to controller |
| ctl_cmd_ready | input | 1 | controller takes command |
| ctl_opcode | output | 8 | command opcode |
| ctl_subcmd | output | 4 | sub-command |
| ctl_len | output | 8 | payload length in bytes |
| ctl_payload | output | 128 | masked payload bytes |
| ctl_src_ptr | output | 32 | source pointer |
| ctl_dst_ptr | output | 32 | destination pointer |
| cpl_valid | input | 1 | completion offered |
| cpl_ready | output | 1 | completion accepted when high |
| cpl_err | input | 1 | completion error flag |
| cpl_code | input | 8 | completion error code |
| cpl_data | input | 128 | four reply words |
| irq | output | 1 | completion interrupt |

## Verification
The main flow is run with four commands from a table:
- The lengths are 16, 5, 0 and 9, so the payload masking is tried at the full width, in the middle of a word and with nothing valid.
- The interrupt request alternates from one command to the next. This separates interrupt-gated completions from silent ones.
- The completions alternate between no error and codes 1 and 7. This shows that the error field is loaded from the completion, holds through idle cycles and is cleared by the next command.

Directed cases cover the following:
- an oversized length;
- writes landing while busy and before the controller has taken the command;
- bus writes into the read buffer;
- reads of the write buffer.

Together they separate ignore behaviour from silent corruption.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BUF_WORDS = 4;
  localparam int unsigned BUF_BYTES = BUF_WORDS * 4;
  localparam int unsigned IDX_W     = $clog2(BUF_WORDS);

  localparam logic [7:0] OFF_CMD = 8'h00;
  localparam logic [7:0] OFF_STS = 8'h04;
  localparam logic [7:0] OFF_SRC = 8'h08;
  localparam logic [7:0] OFF_DST = 8'h0C;
  localparam logic [3:0] PAGE_WBUF = 4'h8;
  localparam logic [3:0] PAGE_RBUF = 4'h9;

  typedef enum logic [7:0] {
    RC_NONE      = 8'd0,
    RC_UNSUP     = 8'd1,
    RC_UNSERVED  = 8'd2,
    RC_CANNOT    = 8'd3,
    RC_INVALID   = 8'd4,
    RC_FAILED    = 8'd5,
    RC_SECURITY  = 8'd6,
    RC_UNSIGNED  = 8'd7
  } rc_e;

  typedef struct packed {
    logic [7:0] len;
    logic [3:0] sub;
    logic       irq_req;
    logic [7:0] opcode;
  } cmd_t;
endpackage

// File: rtl/mbx_wbuf.sv
module mbx_wbuf
  import mbx_pkg::*;
#(
  parameter int unsigned WORDS = BUF_WORDS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [$clog2(WORDS)-1:0]      widx,
  input  logic [WORD_W-1:0]             wdata,
  input  logic [7:0]                    valid_len,
  output logic [WORDS*WORD_W-1:0]       payload
);
  localparam int unsigned NBYTES = WORDS * (WORD_W / 8);

  logic [WORDS*WORD_W-1:0] raw;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        raw[w*WORD_W +: WORD_W] <= '0;
      else if (we && widx == w[$clog2(WORDS)-1:0])
        raw[w*WORD_W +: WORD_W] <= wdata;
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_mask
    assign payload[b*8 +: 8] = (valid_len > 8'(b)) ? raw[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/mbx_rbuf.sv
module mbx_rbuf
  import mbx_pkg::*;
#(
  parameter int unsigned WORDS = BUF_WORDS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [WORDS*WORD_W-1:0]       ldata,
  input  logic [$clog2(WORDS)-1:0]      ridx,
  output logic [WORD_W-1:0]             rdata
);
  logic [WORD_W-1:0] words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    words[w] <= '0;
      else if (load) words[w] <= ldata[w*WORD_W +: WORD_W];
    end

    // R7: reply words change only on a completion
    assert_reply_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(words[w]));
  end

  assign rdata = words[ridx];
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  cmd_t       cmd_in,
  input  logic       sts_clr,
  input  logic       cmd_ready,
  input  logic       cpl_valid,
  input  logic       cpl_err,
  input  logic [7:0] cpl_code,
  output logic       busy,
  output logic       pend,
  output logic       err,
  output logic [7:0] code,
  output logic       irq_flag,
  output logic       cpl_fire,
  output logic       cpl_rdy,
  output cmd_t       cmd_q
);
  logic len_ok;
  assign len_ok   = cmd_in.len <= 8'(BUF_BYTES);
  assign cpl_rdy  = busy & ~pend;
  assign cpl_fire = cpl_rdy & cpl_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      pend  <= 1'b0;
      err   <= 1'b0;
      code  <= RC_NONE;
      cmd_q <= '0;
    end else if (cmd_wr && !busy) begin
      if (len_ok) begin
        busy  <= 1'b1;
        pend  <= 1'b1;
        err   <= 1'b0;
        code  <= RC_NONE;
        cmd_q <= cmd_in;
      end else begin
        err  <= 1'b1;
        code <= RC_INVALID;
      end
    end else if (pend && cmd_ready) begin
      pend <= 1'b0;
    end else if (cpl_fire) begin
      busy <= 1'b0;
      err  <= cpl_err;
      code <= cpl_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         irq_flag <= 1'b0;
    else if (cpl_fire && cmd_q.irq_req) irq_flag <= 1'b1;
    else if (sts_clr)                   irq_flag <= 1'b0;
  end

  assert_busy_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cpl_fire |=> busy);
  assert_busy_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_fire |=> !busy);
  assert_cmd_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !cmd_ready |=> pend && $stable(cmd_q));
  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_wr |=> $stable(cmd_q));
  assert_no_stray_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(cmd_q.irq_req));
  assert_err_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!err && code == 8'd0));
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter logic [7:0] INIT_ID = 8'h5A
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [7:0]                    bus_addr,
  input  logic [WORD_W-1:0]             bus_wdata,
  output logic [WORD_W-1:0]             bus_rdata,
  output logic                          ctl_cmd_valid,
  input  logic                          ctl_cmd_ready,
  output logic [7:0]                    ctl_opcode,
  output logic [3:0]                    ctl_subcmd,
  output logic [7:0]                    ctl_len,
  output logic [BUF_WORDS*WORD_W-1:0]   ctl_payload,
  output logic [WORD_W-1:0]             ctl_src_ptr,
  output logic [WORD_W-1:0]             ctl_dst_ptr,
  input  logic                          cpl_valid,
  output logic                          cpl_ready,
  input  logic                          cpl_err,
  input  logic [7:0]                    cpl_code,
  input  logic [BUF_WORDS*WORD_W-1:0]   cpl_data,
  output logic                          irq
);
  logic       aligned, hit_cmd, hit_sts, hit_src, hit_dst, hit_wbuf, hit_rbuf;
  logic       busy, pend, err, irq_flag, cpl_fire;
  logic [7:0] code;
  logic [IDX_W-1:0] idx;
  logic [WORD_W-1:0] rbuf_word, src_q, dst_q;
  cmd_t       cmd_in, cmd_q;

  assign aligned  = bus_addr[1:0] == 2'b00;
  assign idx      = bus_addr[IDX_W+1:2];
  assign hit_cmd  = aligned && bus_addr == OFF_CMD;
  assign hit_sts  = aligned && bus_addr == OFF_STS;
  assign hit_src  = aligned && bus_addr == OFF_SRC;
  assign hit_dst  = aligned && bus_addr == OFF_DST;
  assign hit_wbuf = aligned && bus_addr[7:4] == PAGE_WBUF;
  assign hit_rbuf = aligned && bus_addr[7:4] == PAGE_RBUF;

  assign cmd_in = '{len: bus_wdata[23:16], sub: bus_wdata[15:12],
                    irq_req: bus_wdata[8], opcode: bus_wdata[7:0]};

  mbx_ctrl u_ctrl (
    .clk, .rst_n,
    .cmd_wr   (bus_wr && hit_cmd),
    .cmd_in   (cmd_in),
    .sts_clr  (bus_wr && hit_sts && bus_wdata[2]),
    .cmd_ready(ctl_cmd_ready),
    .cpl_valid, .cpl_err, .cpl_code,
    .busy, .pend, .err, .code, .irq_flag, .cpl_fire,
    .cpl_rdy  (cpl_ready),
    .cmd_q
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (bus_wr && !busy) begin
      if (hit_src) src_q <= bus_wdata;
      if (hit_dst) dst_q <= bus_wdata;
    end
  end

  mbx_wbuf #(.WORDS(BUF_WORDS)) u_wbuf (
    .clk, .rst_n,
    .we       (bus_wr && hit_wbuf && !busy),
    .widx     (idx),
    .wdata    (bus_wdata),
    .valid_len(cmd_q.len),
    .payload  (ctl_payload)
  );

  mbx_rbuf #(.WORDS(BUF_WORDS)) u_rbuf (
    .clk, .rst_n,
    .load (cpl_fire),
    .ldata(cpl_data),
    .ridx (idx),
    .rdata(rbuf_word)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_cmd)
        bus_rdata = {8'h00, cmd_q.len, cmd_q.sub, 3'b000, cmd_q.irq_req, cmd_q.opcode};
      else if (hit_sts)
        bus_rdata = {8'h00, code, INIT_ID, cmd_q.sub, 1'b0, irq_flag, err, busy};
      else if (hit_src)
        bus_rdata = src_q;
      else if (hit_dst)
        bus_rdata = dst_q;
      else if (hit_rbuf)
        bus_rdata = rbuf_word;
    end
  end

  assign ctl_cmd_valid = pend;
  assign ctl_opcode    = cmd_q.opcode;
  assign ctl_subcmd    = cmd_q.sub;
  assign ctl_len       = cmd_q.len;
  assign ctl_src_ptr   = src_q;
  assign ctl_dst_ptr   = dst_q;
  assign irq           = irq_flag;

  // R9: payload and pointers frozen while a command is in flight
  assert_frozen_inflight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctl_payload) && $stable(ctl_src_ptr) && $stable(ctl_dst_ptr));
  // R11: completion side only open after the command was taken
  assert_cpl_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_ready |-> !ctl_cmd_valid);
  // R5: an oversized length never starts a command
  assert_len_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_cmd_valid |-> ctl_len <= 8'(BUF_BYTES));
endmodule

// File: tb/sim_cmd_mailbox.sv
module sim_cmd_mailbox;
  import mbx_pkg::*;

  typedef struct packed {
    logic [7:0]  op;
    logic [3:0]  sub;
    logic [7:0]  len;
    logic        irq;
    logic        err;
    logic [7:0]  code;
    logic [31:0] seed;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{8'hEE, 4'h3, 8'd16, 1'b1, 1'b0, 8'd0, 32'h11223344},
    '{8'hEF, 4'h5, 8'd5,  1'b0, 1'b1, 8'd1, 32'hA0B0C0D0},
    '{8'hF0, 4'hF, 8'd0,  1'b1, 1'b1, 8'd7, 32'h0F1E2D3C},
    '{8'hEB, 4'h0, 8'd9,  1'b0, 1'b0, 8'd0, 32'h55AA7700}
  };
  localparam logic [7:0] INIT_ID = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic ctl_cmd_valid, ctl_cmd_ready = 0;
  logic [7:0] ctl_opcode, ctl_len;
  logic [3:0] ctl_subcmd;
  logic [127:0] ctl_payload;
  logic [31:0] ctl_src_ptr, ctl_dst_ptr;
  logic cpl_valid = 0, cpl_ready, cpl_err = 0, irq;
  logic [7:0] cpl_code = 0;
  logic [127:0] cpl_data = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmd_mailbox #(.INIT_ID(INIT_ID)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a; #1; d = bus_rdata; bus_rd = 0;
  endtask

  task automatic take_cmd();
    @(negedge clk); ctl_cmd_ready = 1;
    @(negedge clk); ctl_cmd_ready = 0;
  endtask

  task automatic complete(input logic e, input logic [7:0] c, input logic [127:0] d);
    @(negedge clk);
    chk(cpl_ready === 1'b1, "R11 cpl_ready open", cpl_ready, 1);
    cpl_valid = 1; cpl_err = e; cpl_code = c; cpl_data = d;
    @(negedge clk); cpl_valid = 0;
  endtask

  function automatic logic [127:0] exp_payload(input logic [31:0] seed, input logic [7:0] len);
    logic [127:0] raw, p;
    for (int w = 0; w < 4; w++) raw[w*32 +: 32] = seed + 32'(w);
    for (int b = 0; b < 16; b++) p[b*8 +: 8] = (b < len) ? raw[b*8 +: 8] : 8'h00;
    return p;
  endfunction

  function automatic logic [127:0] reply(input logic [31:0] seed);
    logic [127:0] r;
    for (int w = 0; w < 4; w++) r[w*32 +: 32] = ~seed + 32'(w * 3);
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R3 watchdog expired act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic prev_err;
    logic [7:0] prev_code;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(OFF_STS, d);
    chk(d === {16'h0, INIT_ID, 8'h00}, "R1 status after reset", d, {16'h0, INIT_ID, 8'h00});
    chk(irq === 0 && ctl_cmd_valid === 0 && cpl_ready === 0, "R1 outputs idle",
        {irq, ctl_cmd_valid, cpl_ready}, 0);

    prev_err = 0; prev_code = 0;
    foreach (VEC[i]) begin
      for (int w = 0; w < 4; w++) wr(8'h80 + 8'(4*w), VEC[i].seed + 32'(w));
      wr(OFF_SRC, VEC[i].seed ^ 32'h0000FFFF);
      wr(OFF_DST, VEC[i].seed ^ 32'hFFFF0000);
      rd(OFF_STS, d);
      chk(d[1] === prev_err && d[23:16] === prev_code, "R6 error persists while idle",
          {d[23:16], d[1]}, {prev_code, prev_err});
      wr(OFF_CMD, {8'h00, VEC[i].len, VEC[i].sub, 3'b000, VEC[i].irq, VEC[i].op});
      rd(OFF_STS, d);
      chk(d[0] === 1'b1, "R3 busy after command", d[0], 1);
      chk(d[1] === 1'b0 && d[23:16] === 8'h00, "R6 error cleared by command", d[23:16], 0);
      chk(d[7:4] === VEC[i].sub, "R10 command id", d[7:4], VEC[i].sub);
      chk(ctl_cmd_valid === 1 && cpl_ready === 0, "R11 command offered",
          {ctl_cmd_valid, cpl_ready}, 2'b10);
      chk(ctl_opcode === VEC[i].op && ctl_subcmd === VEC[i].sub && ctl_len === VEC[i].len,
          "R2 command fields", {ctl_opcode, ctl_subcmd, ctl_len},
          {VEC[i].op, VEC[i].sub, VEC[i].len});
      chk(ctl_src_ptr === (VEC[i].seed ^ 32'h0000FFFF) && ctl_dst_ptr === (VEC[i].seed ^ 32'hFFFF0000),
          "R2 pointers", {ctl_src_ptr, ctl_dst_ptr},
          {VEC[i].seed ^ 32'h0000FFFF, VEC[i].seed ^ 32'hFFFF0000});
      chk(ctl_payload === exp_payload(VEC[i].seed, VEC[i].len), "R4 masked payload",
          ctl_payload, exp_payload(VEC[i].seed, VEC[i].len));
      take_cmd();
      chk(ctl_cmd_valid === 0, "R11 command taken", ctl_cmd_valid, 0);
      rd(OFF_STS, d);
      chk(d[0] === 1'b1, "R3 busy until completion", d[0], 1);
      complete(VEC[i].err, VEC[i].code, reply(VEC[i].seed));
      rd(OFF_STS, d);
      chk(d[0] === 0 && d[1] === VEC[i].err && d[23:16] === VEC[i].code, "R6 completion status",
          {d[23:16], d[1], d[0]}, {VEC[i].code, VEC[i].err, 1'b0});
      for (int w = 0; w < 4; w++) begin
        rd(8'h90 + 8'(4*w), d);
        chk(d === reply(VEC[i].seed)[w*32 +: 32], "R7 reply word", d, reply(VEC[i].seed)[w*32 +: 32]);
      end
      chk(irq === VEC[i].irq && d !== 32'hx, "R8 irq follows request", irq, VEC[i].irq);
      rd(OFF_STS, d);
      chk(d[2] === VEC[i].irq, "R8 status irq flag", d[2], VEC[i].irq);
      if (VEC[i].irq) begin
        wr(OFF_STS, 32'h4);
        rd(OFF_STS, d);
        chk(irq === 0 && d[2] === 0, "R8 irq cleared by write-one", {irq, d[2]}, 0);
      end
      prev_err = VEC[i].err; prev_code = VEC[i].code;
    end

    // R5 oversized length
    wr(OFF_CMD, {8'h00, 8'd17, 4'h6, 4'h0, 8'h42});
    rd(OFF_STS, d);
    chk(d[0] === 0 && d[1] === 1 && d[23:16] === 8'd4, "R5 length 17 rejected",
        {d[23:16], d[1], d[0]}, {8'd4, 1'b1, 1'b0});
    chk(ctl_cmd_valid === 0 && d[7:4] === 4'h0, "R5 no command issued",
        {ctl_cmd_valid, d[7:4]}, 0);

    // R9 writes while busy
    wr(8'h80, 32'hCAFEF00D);
    wr(OFF_SRC, 32'h00000100);
    wr(OFF_CMD, {8'h00, 8'd4, 4'h2, 4'h0, 8'h11});
    wr(OFF_CMD, {8'h00, 8'd8, 4'h9, 4'h1, 8'h99});
    wr(8'h80, 32'hDEADBEEF);
    wr(OFF_SRC, 32'h00000200);
    chk(ctl_opcode === 8'h11 && ctl_len === 8'd4 && ctl_subcmd === 4'h2, "R9 command kept",
        {ctl_opcode, ctl_len, ctl_subcmd}, {8'h11, 8'd4, 4'h2});
    chk(ctl_payload[31:0] === 32'hCAFEF00D && ctl_src_ptr === 32'h100, "R9 buffer and pointer kept",
        {ctl_payload[31:0], ctl_src_ptr}, {32'hCAFEF00D, 32'h100});
    take_cmd();
    complete(1'b0, 8'd0, {4{32'h12345678}});
    chk(irq === 0, "R8 no irq without request", irq, 0);

    // R7 / R4 buffer direction
    wr(8'h94, 32'hFFFFFFFF);
    rd(8'h94, d);
    chk(d === 32'h12345678, "R7 read buffer write ignored", d, 32'h12345678);
    rd(8'h80, d);
    chk(d === 32'h0, "R4 write buffer reads zero", d, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule